// File: doc/BRIEF.md
# Single-Byte Register Instruction Executor

A compact execution core that runs a stream of one-byte instructions from a byte-wide program memory. The upper nibble of each byte is the opcode. The lower nibble selects one of sixteen 16-bit registers. Three operations are supported:

- decrement the selected register;
- bitwise-invert the selected register;
- a conditional relative branch that adds the selected register to the program counter when register 14 holds a non-negative value.

Any other opcode only steps the program counter. Every instruction takes one clock edge.

Program memory is read combinationally: the core drives the current PC on `pc_addr_o` and executes the byte on `instr_i` at each rising edge while `run_i` is high. While `run_i` is low the core is idle. In that state a test write port can preload registers, and a read port shows any register for checking.

Top module: `exec_core`

## Requirements
- R1: `pc_addr_o` always equals the PC. The instruction byte splits into an opcode in bits 7:4 and a register index in bits 3:0.
- R2: Opcode 4'h9 writes the selected register minus one, modulo 2^16, so 16'h0000 becomes 16'hFFFF.
- R3: Opcode 4'hA writes the bitwise complement of the selected register.
- R4: Opcode 4'hB with bit 15 of register 14 clear sets the PC to PC plus the selected register, modulo 2^16. An offset with bit 15 set therefore jumps backward.
- R5: Opcode 4'hB with bit 15 of register 14 set sets the PC to PC plus one.
- R6: Opcodes 4'h9 and 4'hA, and every opcode other than 4'h9, 4'hA and 4'hB, advance the PC by exactly one. Those other opcodes change no register.
- R7: Only the selected register changes on 4'h9 and 4'hA, and no register changes on 4'hB.
- R8: While `run_i` is low, the PC holds and the test write port writes `tw_data_i` into register `tw_idx_i` on the clock edge. While `run_i` is high, the test write port has no effect.
- R9: An active-low asynchronous reset clears the PC and all sixteen registers to zero.
- R10: `rd_data_o` shows the current contents of register `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Execute the fetched byte on each edge |
| pc_addr_o | output | 16 | Program memory address (current PC) |
| instr_i | input | 8 | Instruction byte at `pc_addr_o` |
| tw_en_i | input | 1 | Test write enable (used only while idle) |
| tw_idx_i | input | 4 | Test write register index |
| tw_data_i | input | 16 | Test write data |
| rd_idx_i | input | 4 | Read port register index |
| rd_data_o | output | 16 | Read port data |

## Verification
The assertions check the PC update on every clock cycle: the one-step advance for decrement and invert, both outcomes of the branch, and the PC holding while idle. They also check that an unwritten register keeps its value. Only the bench scenarios can show the following, because they depend on earlier history:

- the wrapped values that decrement and invert write;
- that writes reach only the selected register;
- that test writes are refused during a run;
- backward branches through a negative offset;
- register contents after reset.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int XLEN     = 16;
  localparam int NREG     = 16;
  localparam int IDXW     = $clog2(NREG);
  localparam int OPW      = 4;
  localparam int INSW     = OPW + IDXW;
  localparam int TEST_REG = 14;

  localparam logic [OPW-1:0] OP_DEC = 4'h9;
  localparam logic [OPW-1:0] OP_INV = 4'hA;
  localparam logic [OPW-1:0] OP_BPZ = 4'hB;
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile
  import exec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [IDXW-1:0] ra_idx_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [IDXW-1:0] rb_idx_i,
  output logic [XLEN-1:0] rb_data_o,
  output logic [XLEN-1:0] rt_data_o
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     regs_q[g] <= '0;
      else if (we_i && wr_idx_i == g)  regs_q[g] <= wr_data_i;
    end

    p_unwritten_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && wr_idx_i == g) |=> $stable(regs_q[g]));
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
  assign rt_data_o = regs_q[TEST_REG];
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] sel_data_i,
  input  logic [XLEN-1:0] test_data_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            wr_en_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic [XLEN-1:0] pc_next_o
);
  logic [XLEN-1:0] pc_inc;
  assign pc_inc = pc_i + XLEN'(1);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = sel_data_i;
    pc_next_o = pc_inc;
    case (op_i)
      OP_DEC: begin
        wr_en_o   = 1'b1;
        wr_data_o = sel_data_i - XLEN'(1);
      end
      OP_INV: begin
        wr_en_o   = 1'b1;
        wr_data_o = ~sel_data_i;
      end
      OP_BPZ: begin
        if (!test_data_i[XLEN-1]) pc_next_o = pc_i + sel_data_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exec_pc.sv
module exec_pc
  import exec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] pc_next_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (en_i) pc_q <= pc_next_i;
  end

  assign pc_o = pc_q;

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_q));
endmodule

// File: rtl/exec_core.sv
module exec_core
  import exec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  output logic [15:0] pc_addr_o,
  input  logic [7:0]  instr_i,
  input  logic        tw_en_i,
  input  logic [3:0]  tw_idx_i,
  input  logic [15:0] tw_data_i,
  input  logic [3:0]  rd_idx_i,
  output logic [15:0] rd_data_o
);
  logic [OPW-1:0]  op;
  logic [IDXW-1:0] sel;
  logic [XLEN-1:0] sel_data, test_data, pc, pc_next, alu_wdata, wdata;
  logic            alu_we, we;
  logic [IDXW-1:0] widx;

  assign op  = instr_i[INSW-1:IDXW];
  assign sel = instr_i[IDXW-1:0];

  // run owns the write port; test writes only when idle
  assign we    = run_i ? alu_we : tw_en_i;
  assign widx  = run_i ? sel : tw_idx_i;
  assign wdata = run_i ? alu_wdata : tw_data_i;

  exec_regfile i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_idx_i  (widx),
    .wr_data_i (wdata),
    .ra_idx_i  (sel),
    .ra_data_o (sel_data),
    .rb_idx_i  (rd_idx_i),
    .rb_data_o (rd_data_o),
    .rt_data_o (test_data)
  );

  exec_alu i_alu (
    .op_i        (op),
    .sel_data_i  (sel_data),
    .test_data_i (test_data),
    .pc_i        (pc),
    .wr_en_o     (alu_we),
    .wr_data_o   (alu_wdata),
    .pc_next_o   (pc_next)
  );

  exec_pc i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run_i),
    .pc_next_i (pc_next),
    .pc_o      (pc)
  );

  assign pc_addr_o = pc;

  p_step_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && op != OP_BPZ |=> pc_addr_o == $past(pc_addr_o) + 16'd1);

  p_branch_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && op == OP_BPZ && !test_data[15] |=> pc_addr_o == $past(pc_addr_o + sel_data));

  p_branch_not_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && op == OP_BPZ && test_data[15] |=> pc_addr_o == $past(pc_addr_o) + 16'd1);
endmodule

// File: tb/test_exec_core.sv
module test_exec_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] pc_addr_o;
  logic [7:0]  instr_i = 8'h00;
  logic        tw_en_i = 1'b0;
  logic [3:0]  tw_idx_i = 4'h0;
  logic [15:0] tw_data_i = 16'h0;
  logic [3:0]  rd_idx_i = 4'h0;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [16];
  logic [15:0] mpc;

  always #4 clk_i = ~clk_i;

  exec_core i_exec_core (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pc(logic [7:0] ins, logic [15:0] pc);
    if (ins[7:4] == 4'hB && !mdl[14][15]) return pc + mdl[ins[3:0]];
    return pc + 16'd1;
  endfunction

  function automatic logic [15:0] exp_reg(logic [7:0] ins);
    case (ins[7:4])
      4'h9:    return mdl[ins[3:0]] - 16'd1;
      4'hA:    return ~mdl[ins[3:0]];
      default: return mdl[ins[3:0]];
    endcase
  endfunction

  task automatic rd_chk(string req, logic [3:0] idx);
    rd_idx_i = idx;
    #1;
    chk(req, rd_data_o, mdl[idx]);
  endtask

  task automatic wr_reg(logic [3:0] idx, logic [15:0] val);
    @(negedge clk_i);
    run_i = 1'b0; tw_en_i = 1'b1; tw_idx_i = idx; tw_data_i = val;
    @(negedge clk_i);
    tw_en_i = 1'b0;
    mdl[idx] = val;
  endtask

  // executes one byte; optionally drives a test write that must be ignored
  task automatic exec(logic [7:0] ins, bit poke, string req);
    logic [15:0] nv;
    logic [3:0]  other;
    @(negedge clk_i);
    run_i = 1'b1; instr_i = ins;
    tw_en_i = poke; tw_idx_i = 4'($urandom); tw_data_i = 16'($urandom);
    nv  = exp_reg(ins);
    mpc = exp_pc(ins, mpc);
    mdl[ins[3:0]] = nv;
    @(negedge clk_i);
    run_i = 1'b0; tw_en_i = 1'b0;
    chk({req, " R1 pc"}, pc_addr_o, mpc);
    rd_chk({req, " R10 sel"}, ins[3:0]);
    other = 4'($urandom);
    rd_chk("R7 other", other);
    if (poke) rd_chk("R8 poke ignored", tw_idx_i);
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    #3;
    mpc = '0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    chk("R9 pc", pc_addr_o, 16'h0);
    for (int i = 0; i < 16; i++) rd_chk("R9 reg", 4'(i));
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 16'h1, 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk_i);
    do_reset();

    // R8: idle writes land, PC holds
    wr_reg(4'd3, 16'hFFFE);
    wr_reg(4'd5, 16'h0000);
    wr_reg(4'd14, 16'h8000);
    chk("R8 pc hold", pc_addr_o, mpc);
    rd_chk("R8 write", 4'd3);

    exec(8'h95, 1'b0, "R2 wrap");        // 0x0000 -> 0xFFFF
    rd_chk("R2 wrap value", 4'd5);
    exec(8'hA3, 1'b0, "R3 invert");      // 0xFFFE -> 0x0001
    exec(8'hB3, 1'b0, "R5 negative");    // r14 negative: PC+1
    exec(8'h07, 1'b0, "R6 nop");
    exec(8'hF2, 1'b0, "R6 nop");

    wr_reg(4'd14, 16'h7FFF);
    wr_reg(4'd3, 16'hFFFC);              // backward 4
    exec(8'hB3, 1'b0, "R4 backward");
    exec(8'hBE, 1'b0, "R4 self offset");
    wr_reg(4'd14, 16'h0000);
    wr_reg(4'd6, 16'h0000);
    exec(8'hB6, 1'b0, "R4 zero offset");
    exec(8'h9E, 1'b0, "R2 test reg");    // r14 -> 0xFFFF
    exec(8'hB6, 1'b0, "R5 after dec");
    exec(8'h91, 1'b1, "R8 run poke");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] ins;
      if (n % 37 == 0) wr_reg(4'($urandom), 16'($urandom));
      case ($urandom % 5)
        0:       ins = {4'h9, 4'($urandom)};
        1:       ins = {4'hA, 4'($urandom)};
        2, 3:    ins = {4'hB, 4'($urandom)};
        default: ins = 8'($urandom);
      endcase
      exec(ins, 1'($urandom), "R6 random");
    end

    for (int i = 0; i < 16; i++) rd_chk("R7 final", 4'(i));

    @(negedge clk_i);
    do_reset();
    chk("R9 pc after", pc_addr_o, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule